// File: doc/BRIEF.md
# Register-Mapped Random Word Controller

This block sits on a simple 32-bit register bus and controls a pseudo-random word source. Software finds an identification word, a command register, a control register, a status register and a data port. Reading the data port returns a 32-bit word from an internal linear-feedback shift register, which then moves one step. Two operations, seeding and self-test, can be started from the command register. Each one goes from idle to running, and after a fixed number of clock cycles it reaches done.

When an operation reaches done, a level interrupt is raised unless software has masked done events. Software lowers the interrupt by writing either of the two clear bits in the command register. A software-reset command puts both operations back to idle and clears the control bits. The status register reports a fixed output queue that is always full, and it always reports a fresh seed as available. Register reads are combinational from the address; every write and every data-port advance takes effect on the rising clock edge.

Top module: `rng_mmio_ctrl`

## Requirements
- R1: Offset 0x00 reads 0x1000_0240: type 1 in bits 31:28, major 2 in bits 15:8, minor 0x40 in bits 7:0.
- R2: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C and 0x14 return zero. Writes there, and writes to the read-only offsets 0x00, 0x0C and 0x14, change no state.
- R3: The control register at 0x08 stores bit 6 (error mask), bit 5 (done mask) and bit 4 (auto-seed) as written and reads them back. All its other bits read zero.
- R4: Writing command 0x04 with bit 1 starts seeding and with bit 0 starts self-test. While an operation runs, reading the command register shows bit 1 (seeding) or bit 0 (self-test), and status bit 1 (busy) is set with bit 0 (ready) clear.
- R5: An operation stays running for exactly RUN_CYCLES clock cycles after the write edge and then becomes done. Status bit 5 shows seed done and bit 4 shows self-test done, the command bit clears, and ready returns. A new start clears done back to running.
- R6: Status at 0x0C always reads bits 15:12 = 5, bits 11:8 = 5, bit 6 = 1, and zero in bits 31:16, bit 7 and bits 3:2. An idle block reads 0x0000_5541.
- R7: When an operation reaches done, irq rises on the next edge, but only if the done mask (control bit 5) is clear. irq stays high until it is cleared.
- R8: A command write with bit 5 or bit 4 set lowers irq on that edge. If an operation finishes on the same edge, irq is set instead.
- R9: Hardware reset, and a command write with bit 6 set, return both operations to idle, clear all control bits and lower irq. A start bit in the same write as bit 6 still starts its operation.
- R10: Offset 0x14 returns the current generator state s. Each read advances it to {s[30:0], s[31]^s[21]^s[1]^s[0]}. After hardware reset the state is SEED_CONST (default 0x6A09_E667).
- R11: A seed start loads the generator with SEED_CONST XOR k, where k is the number of rising edges since reset was released, counted before the write edge. If that value is zero, SEED_CONST is loaded instead.
- R12: A start written while the same operation is already running restarts its full RUN_CYCLES count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe; advances the generator when addr is 0x14 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| irq | output | 1 | Level done interrupt |

## Verification
The bench targets three timing corners. The first is the exact cycle an operation leaves running: a sequencer that is off by one reads done one cycle early, or is still busy when it should be done. The second is a clear command that lands on the same edge as a finish: a design that lets the clear win loses that completion, and irq stays low. The third is a restart during a run: a design that keeps the old count finishes early. The bench also tracks the generator with its own model across hardware reset, reads and reseeds. A wrong tap, a reseed that ignores the edge count, or an advance on reads of other offsets all produce a word that differs from the model. Masked completions, and soft resets issued mid-run or together with a start, confirm that irq and the state bits change only as required.

// File: rtl/rng_mmio_pkg.sv
// Package: shared types, register offsets, bit positions and the generator step.
// Assumes a 32-bit data path; offsets are byte addresses.
package rng_mmio_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_OPS  = 2;
    localparam int unsigned OP_TEST  = 0;   // index equals its command bit
    localparam int unsigned OP_SEED  = 1;

    localparam int unsigned OFS_ID   = 'h00;
    localparam int unsigned OFS_CMD  = 'h04;
    localparam int unsigned OFS_CTL  = 'h08;
    localparam int unsigned OFS_STS  = 'h0C;
    localparam int unsigned OFS_DATA = 'h14;

    localparam int unsigned CMD_SWRST  = 6;
    localparam int unsigned CMD_CLRERR = 5;
    localparam int unsigned CMD_CLRIRQ = 4;

    localparam int unsigned CTL_ERRMSK  = 6;
    localparam int unsigned CTL_DONEMSK = 5;
    localparam int unsigned CTL_AUTO    = 4;

    localparam logic [31:0] ID_WORD   = 32'h1000_0240;
    localparam logic [3:0]  QUEUE_CAP = 4'd5;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RUN  = 2'd1,
        OP_DONE = 2'd2
    } op_state_e;

    // One step of the maximal-length 32-bit shift register (taps 32,22,2,1).
    function automatic logic [DATA_W-1:0] gen_step(input logic [DATA_W-1:0] s);
        return {s[DATA_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

endpackage

// File: rtl/rng_op_seq.sv
// Module: idle/run/done sequencer for one long-running operation.
// Assumes RUN_CYCLES >= 1. A start always (re)enters the run state with a fresh
// count; an abort drops to idle unless a start arrives in the same cycle.
module rng_op_seq
    import rng_mmio_pkg::*;
#(
    parameter int unsigned RUN_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_i,
    input  logic      abort_i,
    output op_state_e state_o,
    output logic      finish_o
);
    localparam int unsigned CNT_W = $clog2(RUN_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_CYCLES - 1);

    op_state_e        st_q;
    logic [CNT_W-1:0] cnt_q;

    // Completion happens on the edge where the last run cycle ends undisturbed.
    assign finish_o = (st_q == OP_RUN) && (cnt_q == LAST) && !start_i && !abort_i;
    assign state_o  = st_q;

    // State and run counter update; start beats abort, abort beats counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OP_IDLE;
            cnt_q <= '0;
        end else if (start_i) begin
            st_q  <= OP_RUN;
            cnt_q <= '0;
        end else if (abort_i) begin
            st_q  <= OP_IDLE;
            cnt_q <= '0;
        end else if (st_q == OP_RUN) begin
            if (cnt_q == LAST) begin
                st_q  <= OP_DONE;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rng_word_src.sv
// Module: pseudo-random word source with a free-running edge counter for reseeding.
// Assumes SEED_CONST is nonzero. Reseed takes priority over an advance.
module rng_word_src
    import rng_mmio_pkg::*;
#(
    parameter logic [DATA_W-1:0] SEED_CONST = 32'h6A09_E667
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              reseed_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] state_q;
    logic [DATA_W-1:0] tick_q;
    logic [DATA_W-1:0] mix;
    logic [DATA_W-1:0] reload;

    // Reload value: constant mixed with elapsed edges, never all-zero.
    assign mix    = SEED_CONST ^ tick_q;
    assign reload = (mix == '0) ? SEED_CONST : mix;
    assign word_o = state_q;

    // Free-running edge counter since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= '0;
        else        tick_q <= tick_q + 1'b1;
    end

    // Generator state: reload on reseed, step on data-port read.
    always_ff @(posedge clk) begin
        if (!rst_n)        state_q <= SEED_CONST;
        else if (reseed_i) state_q <= reload;
        else if (adv_i)    state_q <= gen_step(state_q);
    end

endmodule

// File: rtl/rng_irq_hold.sv
// Module: level interrupt flop; a set in the same cycle as a clear wins.
// Assumes set_i and clr_i are single-cycle request strobes.
module rng_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    logic irq_q;

    assign irq_o = irq_q;

    // Hold the interrupt level between set and clear requests.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_q <= 1'b0;
        else if (set_i) irq_q <= 1'b1;
        else if (clr_i) irq_q <= 1'b0;
    end

endmodule

// File: rtl/rng_mmio_ctrl.sv
// Module: register front end of the random word controller.
// Decodes bus writes into commands and control bits, runs the seed and
// self-test sequencers, drives the done interrupt and muxes read data.
// Assumes one access per cycle, reads free of side effects except on the
// data port, and ADDR_W wide enough to hold offset 0x14.
module rng_mmio_ctrl
    import rng_mmio_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 12,
    parameter int unsigned       RUN_CYCLES = 16,
    parameter logic [31:0]       SEED_CONST = 32'h6A09_E667
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(OFS_ID);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
    localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_CTL);
    localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'(OFS_STS);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

    logic                cmd_wr;
    logic                ctl_wr;
    logic                sw_rst;
    logic                clr_req;
    logic [NUM_OPS-1:0]  op_start;
    logic [NUM_OPS-1:0]  op_fin;
    logic [NUM_OPS-1:0]  op_running;
    logic [NUM_OPS-1:0]  op_done;
    op_state_e           op_st [NUM_OPS];
    logic                fin_any;
    logic                busy;
    logic                err_mask_q;
    logic                done_mask_q;
    logic                auto_seed_q;
    logic [DATA_W-1:0]   rand_word;
    logic                unused_wbits;

    // Write decode for the two writable registers.
    assign cmd_wr   = wr_en && (addr == A_CMD);
    assign ctl_wr   = wr_en && (addr == A_CTL);
    assign sw_rst   = cmd_wr && wdata[CMD_SWRST];
    assign clr_req  = (cmd_wr && (wdata[CMD_CLRERR] || wdata[CMD_CLRIRQ])) || sw_rst;
    assign op_start = wdata[NUM_OPS-1:0] & {NUM_OPS{cmd_wr}};
    assign unused_wbits = ^{wdata[31:7], wdata[3:2]};

    // One sequencer per operation; command bit index selects the operation.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        rng_op_seq #(
            .RUN_CYCLES (RUN_CYCLES)
        ) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .start_i  (op_start[g]),
            .abort_i  (sw_rst),
            .state_o  (op_st[g]),
            .finish_o (op_fin[g])
        );
        assign op_running[g] = (op_st[g] == OP_RUN);
        assign op_done[g]    = (op_st[g] == OP_DONE);
    end

    assign fin_any = |op_fin;
    assign busy    = |op_running;

    // Control bits: loaded by a control write, cleared by either reset.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            err_mask_q  <= 1'b0;
            done_mask_q <= 1'b0;
            auto_seed_q <= 1'b0;
        end else if (ctl_wr) begin
            err_mask_q  <= wdata[CTL_ERRMSK];
            done_mask_q <= wdata[CTL_DONEMSK];
            auto_seed_q <= wdata[CTL_AUTO];
        end
    end

    rng_word_src #(
        .SEED_CONST (SEED_CONST)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_i    (rd_en && (addr == A_DATA)),
        .reseed_i (op_start[OP_SEED]),
        .word_o   (rand_word)
    );

    rng_irq_hold u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fin_any && !done_mask_q),
        .clr_i (clr_req),
        .irq_o (irq)
    );

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        case (addr)
            A_ID:   rdata = ID_WORD;
            A_CMD:  rdata = {30'b0, op_running[OP_SEED], op_running[OP_TEST]};
            A_CTL:  rdata = {25'b0, err_mask_q, done_mask_q, auto_seed_q, 4'b0};
            A_STS:  rdata = {16'b0, QUEUE_CAP, QUEUE_CAP, 1'b0, 1'b1,
                             op_done[OP_SEED], op_done[OP_TEST], 2'b0, busy, !busy};
            A_DATA: rdata = rand_word;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rng_mmio_ctrl_chk.sv
// Module: property checker for rng_mmio_ctrl, attached by bind.
// Assumes the internal names fin_any, done_mask_q, err_mask_q, auto_seed_q
// and rand_word exist in the top module.
module rng_mmio_ctrl_chk
    import rng_mmio_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              irq,
    input logic              fin_any,
    input logic              done_mask_q,
    input logic              err_mask_q,
    input logic              auto_seed_q,
    input logic [31:0]       rand_word
);
    logic mapped;
    logic cmd_wr;
    assign mapped = (addr == ADDR_W'(OFS_ID))  || (addr == ADDR_W'(OFS_CMD)) ||
                    (addr == ADDR_W'(OFS_CTL)) || (addr == ADDR_W'(OFS_STS)) ||
                    (addr == ADDR_W'(OFS_DATA));
    assign cmd_wr = wr_en && (addr == ADDR_W'(OFS_CMD));

    a_r1_id_word: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_ID)) |-> (rdata == 32'h1000_0240));

    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (rdata == 32'h0));

    a_r4_busy_xor_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_STS)) |-> (rdata[1] != rdata[0]));

    a_r6_status_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_STS)) |-> (rdata[15:6] == 10'b0101_0101_01));

    a_r7_rise_needs_unmasked_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(fin_any && !done_mask_q));

    a_r8_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (wdata[5] || wdata[4]) && !fin_any) |=> !irq);

    a_r9_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && wdata[6]) |=> (!irq && !done_mask_q && !err_mask_q && !auto_seed_q));

    a_r10_step_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(OFS_DATA)) && !(cmd_wr && wdata[1]))
        |=> (rand_word == gen_step($past(rand_word))));

endmodule

bind rng_mmio_ctrl rng_mmio_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wdata       (wdata),
    .rdata       (rdata),
    .irq         (irq),
    .fin_any     (fin_any),
    .done_mask_q (done_mask_q),
    .err_mask_q  (err_mask_q),
    .auto_seed_q (auto_seed_q),
    .rand_word   (rand_word)
);

// File: tb/rng_mmio_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: driver tasks queue expected items; a monitor compares them after each drive.
module rng_mmio_ctrl_bench;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned N      = 16;
    localparam logic [31:0] SEEDK  = 32'h6A09_E667;
    localparam logic [11:0] ID = 12'h000, CMD = 12'h004, CTL = 12'h008,
                            STS = 12'h00C, DAT = 12'h014;

    typedef struct {
        bit          do_rd;
        logic [31:0] exp_rd;
        bit          do_irq;
        bit          exp_irq;
        string       tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              irq;

    int          checks = 0;
    int          errors = 0;
    item_t       q[$];
    logic [31:0] edges = '0;
    logic [31:0] exp_gen = SEEDK;

    always #2 clk = ~clk;

    rng_mmio_ctrl #(.ADDR_W(ADDR_W), .RUN_CYCLES(N), .SEED_CONST(SEEDK)) u_rng_mmio_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq));

    // Bench copy of the elapsed-edge count used for reseeding.
    always @(posedge clk) begin
        if (!rst_n) edges <= '0;
        else        edges <= edges + 1;
    end

    function automatic logic [31:0] model_step(input logic [31:0] s);
        logic fb;
        fb = s[31] ^ s[21] ^ s[1] ^ s[0];
        return {s[30:0], fb};
    endfunction

    // One bus cycle: drive, queue expectations, update the generator model.
    task automatic op(input bit w, input bit r, input logic [11:0] a, input logic [31:0] d,
                      input bit crd, input logic [31:0] erd, input bit cirq, input bit eirq,
                      input string tag);
        item_t it;
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d;
        if (crd || cirq) begin
            it.do_rd = crd; it.exp_rd = erd; it.do_irq = cirq; it.exp_irq = eirq; it.tag = tag;
            q.push_back(it);
        end
        if (r && a == DAT) exp_gen = model_step(exp_gen);
        if (w && a == CMD && d[1]) exp_gen = ((SEEDK ^ edges) == 0) ? SEEDK : (SEEDK ^ edges);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        op(1, 0, a, d, 0, 0, 0, 0, "");
    endtask
    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        op(0, 1, a, 0, 1, e, 0, 0, tag);
    endtask
    task automatic rdi(input logic [11:0] a, input logic [31:0] e, input bit ei, input string tag);
        op(0, 1, a, 0, 1, e, 1, ei, tag);
    endtask
    task automatic irqchk(input bit ei, input string tag);
        op(0, 0, 12'hFFC, 0, 0, 0, 1, ei, tag);
    endtask
    task automatic rd_gen(input string tag);
        op(0, 1, DAT, 0, 1, exp_gen, 0, 0, tag);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) op(0, 0, 12'hFFC, 0, 0, 0, 0, 0, "");
    endtask

    // Monitor: compare queued expectations just after the drive settles.
    always begin
        @(negedge clk);
        #1;
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.do_rd) begin
                checks++;
                if (rdata !== it.exp_rd) begin
                    errors++;
                    $display("FAIL %s: rdata=%08h expected=%08h", it.tag, rdata, it.exp_rd);
                end
            end
            if (it.do_irq) begin
                checks++;
                if (irq !== it.exp_irq) begin
                    errors++;
                    $display("FAIL %s: irq=%0b expected=%0b", it.tag, irq, it.exp_irq);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: cycles=100000 expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state: R1, R6, R9, R10
        rd(ID, 32'h1000_0240, "R1 id word");
        rdi(STS, 32'h5541, 0, "R6 R9 idle status after reset");
        rd(CTL, 0, "R9 control after reset");
        rd(CMD, 0, "R9 command after reset");
        rd_gen("R10 first word is seed constant");
        rd_gen("R10 second word one step on");
        rd_gen("R10 third word");
        // Control readback R3 and unmapped offsets R2
        wr(CTL, 32'hFFFF_FFFF);
        rd(CTL, 32'h70, "R3 all ones written");
        wr(CTL, 32'h20);
        rd(CTL, 32'h20, "R3 done mask only");
        wr(12'h018, 32'hFF); wr(STS, 32'hFF); wr(ID, 32'h7F); wr(DAT, 32'h7F);
        rd(CTL, 32'h20, "R2 writes elsewhere ignored");
        rdi(STS, 32'h5541, 0, "R2 status unchanged by write");
        rd(12'h018, 0, "R2 unmapped 0x18");
        rd(12'h010, 0, "R2 unmapped 0x10");
        rd(12'h015, 0, "R2 unaligned 0x15");
        rd_gen("R2 data port unchanged by write");
        // Seed run R4, R5, R7, R11
        wr(CTL, 0);
        wr(CMD, 32'h2);
        rd(CMD, 32'h2, "R4 seeding shows in command");
        rd(STS, 32'h5542, "R4 busy while seeding");
        idle(N - 3);
        rdi(STS, 32'h5542, 0, "R5 still running in last run cycle");
        rdi(STS, 32'h5561, 1, "R5 R7 seed done and irq raised");
        rd(CMD, 0, "R5 command bit cleared");
        rd_gen("R11 reseeded word");
        rd_gen("R11 step after reseed");
        // Clear interrupt, self-test, clear via error bit R8
        wr(CMD, 32'h10);
        irqchk(0, "R8 clear-interrupt lowers irq");
        wr(CMD, 32'h1);
        rd(CMD, 32'h1, "R4 self-test shows in command");
        idle(N - 2);
        rd(STS, 32'h5562, "R5 self-test still running");
        rdi(STS, 32'h5571, 1, "R5 R7 self-test done");
        wr(CMD, 32'h20);
        irqchk(0, "R8 clear-error lowers irq");
        // Set wins over clear on the same edge R8
        wr(CMD, 32'h2);
        idle(N - 1);
        wr(CMD, 32'h10);
        rdi(STS, 32'h5571, 1, "R8 finish beats clear");
        // Masked completion R7
        wr(CTL, 32'h20);
        wr(CMD, 32'h10);
        irqchk(0, "R8 cleared before masked run");
        wr(CMD, 32'h1);
        idle(N + 2);
        rdi(STS, 32'h5571, 0, "R7 masked done keeps irq low");
        // Restart during run R12
        wr(CTL, 0);
        wr(CMD, 32'h2);
        idle(N - 3);
        wr(CMD, 32'h2);
        idle(N - 1);
        rd(STS, 32'h5552, "R12 restart extends run");
        rdi(STS, 32'h5571, 1, "R12 done after restart count");
        rd_gen("R11 word after restart reseed");
        // Soft reset R9
        wr(CTL, 32'h70);
        wr(CMD, 32'h40);
        rd(CTL, 0, "R9 soft reset clears control");
        rdi(STS, 32'h5541, 0, "R9 soft reset idles ops and irq");
        rd(CMD, 0, "R9 command idle");
        wr(CMD, 32'h1);
        wr(CMD, 32'h40);
        idle(N + 2);
        rdi(STS, 32'h5541, 0, "R9 soft reset aborts run");
        wr(CMD, 32'h41);
        rd(CMD, 32'h1, "R9 start beside soft reset runs");
        idle(N + 2);
        rdi(STS, 32'h5551, 1, "R9 run after soft reset completes");
        idle(3);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule